// File: doc/BRIEF.md
# Dual-Phase Circular Link Recorder

This block records eight byte-wide receive lanes into one circular trace memory whose word holds only four lanes' bytes plus four flag bits. Each incoming word is split in two. In the cycle the word is accepted, the block writes lanes 0 to 3. In the next cycle it writes lanes 4 to 3+4. The write clock therefore runs at twice the lane word rate. For example, lanes at 30 MHz need a 60 MHz block clock.

Recording runs without end, and the newest data overwrites the oldest. A stop request lets the pending second half finish, then freezes the pointer, a sticky wrapped flag and the memory. While frozen, a host reads stored words by address. The oldest entry sits at the frozen pointer when wrapped is set, and at address 0 otherwise. A restart clears the frozen state and recording begins again.

The incoming side is valid/ready. A word transfers in a cycle where both `in_valid` and `in_ready` are high. The sender must hold its word while `in_ready` is low. `in_ready` drops in three cases: during the second-half cycle, from a stop request until the freeze, and while frozen. The memory write strobe is also brought out so an external store can mirror the trace.

Top module: `link_ring_recorder`

## Requirements
- R1: `in_ready` is high only when the block is not frozen, no second half is pending, and no stop is requested or pending. It is therefore low in the cycle after every transfer, which limits the rate to at most one incoming word every two cycles.
- R2: A transfer writes a word in the same cycle that holds lanes 0-3 with bit 35 = 0. The following cycle writes a word that holds lanes 4-7 with bit 35 = 1. Lane k's byte sits at bits [8*(k mod 4)+7 : 8*(k mod 4)].
- R3: Bit 34 of each written word is the OR of the four control flags of the lanes in that half. Bits 33:32 are zero.
- R4: After reset the write address starts at 0. It advances by one on every write and wraps from DEPTH-1 to 0. `wr_ptr` shows the next address to be written.
- R5: `wrapped` sets when the address wraps from DEPTH-1 to 0. It then stays set until a restart.
- R6: A stop request pulse causes a freeze once any pending second half has been written. While frozen there are no writes, `in_ready` is low, and `wr_ptr` holds its value.
- R7: Take a cycle with `host_rd_en` high. If the block is frozen, `host_rdata` shows the stored word at `host_addr` on the next cycle. If it is recording, `host_rdata` shows zero on the next cycle.
- R8: A restart while frozen clears `frozen` and `wrapped` and sets `wr_ptr` to 0. A restart while recording has no effect, and a stop request while frozen has no effect.
- R9: Reset leaves `frozen`, `wrapped`, `wr_ptr`, `mem_we` and `host_rdata` at zero, with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, twice the lane word rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming word valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_lanes | input | LANES*LANE_W | Lane bytes, lane k at bits [8k+7:8k] |
| in_ctrl | input | LANES | Per-lane control-character flag |
| stop_req | input | 1 | Stop pulse |
| restart | input | 1 | Restart pulse (acts while frozen) |
| mem_we | output | 1 | Trace memory write strobe |
| mem_addr | output | ADDR_W | Trace memory write address |
| mem_wdata | output | 36 | Trace memory write word |
| frozen | output | 1 | Recording is stopped |
| wrapped | output | 1 | Buffer has wrapped since last restart |
| wr_ptr | output | ADDR_W | Next write address |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host read address |
| host_rdata | output | 36 | Host read data, one cycle after strobe |

## Verification
The bench builds the block with ADDR_W = 3, which gives an eight-word ring. Six incoming words then make twelve writes. That drives the pointer across the DEPTH-1 to 0 boundary and shows `wrapped` rising on exactly the fourth word. A stop issued during a second-half cycle then exercises the deferred freeze. A full readout of the small ring compares every stored word, including overwritten ones, against an independent model.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int EXTRA_W  = 4;
  localparam int HALF_BIT = 3;  // offset inside the extra field
  localparam int CTRL_BIT = 2;
endpackage

// File: rtl/lane_packer.sv
module lane_packer #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int HALF_N = LANES / 2,
  localparam int DATA_W = HALF_N * LANE_W,
  localparam int WORD_W = DATA_W + rec_pkg::EXTRA_W
) (
  input  logic [LANES*LANE_W-1:0] lanes,
  input  logic [LANES-1:0]        ctrl,
  output logic [WORD_W-1:0]       lo_word,
  output logic [WORD_W-1:0]       hi_word
);
  logic [1:0][WORD_W-1:0] words;

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      words[h] = '0;
      words[h][DATA_W-1:0] = lanes[h*DATA_W +: DATA_W];
      words[h][DATA_W + rec_pkg::CTRL_BIT] = |ctrl[h*HALF_N +: HALF_N];
      words[h][DATA_W + rec_pkg::HALF_BIT] = (h == 1);
    end
  end

  assign lo_word = words[0];
  assign hi_word = words[1];
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              stop_req,
  input  logic              restart,
  output logic              in_ready,
  output logic              accept,
  output logic              pend_hi,
  output logic              we,
  output logic [ADDR_W-1:0] ptr,
  output logic              frozen,
  output logic              wrapped
);
  logic stop_pend;

  assign in_ready = ~frozen & ~pend_hi & ~stop_pend & ~stop_req;
  assign accept   = in_valid & in_ready;
  assign we       = accept | pend_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; frozen <= 1'b0; wrapped <= 1'b0;
      pend_hi <= 1'b0; stop_pend <= 1'b0;
    end else if (frozen) begin
      if (restart) begin
        frozen <= 1'b0; wrapped <= 1'b0; ptr <= '0;
      end
    end else begin
      pend_hi <= accept;
      if (we) begin
        ptr <= ptr + 1'b1;
        if (ptr == {ADDR_W{1'b1}}) wrapped <= 1'b1;
      end
      if ((stop_req | stop_pend) & ~pend_hi) begin
        frozen <= 1'b1; stop_pend <= 1'b0;
      end else if (stop_req) begin
        stop_pend <= 1'b1;
      end
    end
  end

  AST_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (we && !in_ready)); // R1
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R4
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !(frozen && restart)) |=> wrapped); // R5
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (!we && !in_ready)); // R6
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !restart) |=> (frozen && $stable(ptr))); // R6
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && restart) |=> (!frozen && !wrapped && ptr == '0)); // R8
endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              rd_ok,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_ok ? mem[raddr] : '0;
  end

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_ok) |=> (rdata == '0)); // R7
endmodule

// File: rtl/link_ring_recorder.sv
module link_ring_recorder #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 4,
  localparam int WORD_W = (LANES / 2) * LANE_W + rec_pkg::EXTRA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*LANE_W-1:0] in_lanes,
  input  logic [LANES-1:0]        in_ctrl,
  input  logic                    stop_req,
  input  logic                    restart,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  output logic                    frozen,
  output logic                    wrapped,
  output logic [ADDR_W-1:0]       wr_ptr,
  input  logic                    host_rd_en,
  input  logic [ADDR_W-1:0]       host_addr,
  output logic [WORD_W-1:0]       host_rdata
);
  logic [WORD_W-1:0] lo_word, hi_word, hi_q;
  logic accept, pend_hi;

  lane_packer #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
    .lanes(in_lanes), .ctrl(in_ctrl), .lo_word(lo_word), .hi_word(hi_word));

  ring_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stop_req(stop_req),
    .restart(restart), .in_ready(in_ready), .accept(accept),
    .pend_hi(pend_hi), .we(mem_we), .ptr(wr_ptr), .frozen(frozen),
    .wrapped(wrapped));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (accept) hi_q <= hi_word;
  end

  assign mem_addr  = wr_ptr;
  assign mem_wdata = pend_hi ? hi_q : lo_word;

  ring_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr),
    .wdata(mem_wdata), .rd_en(host_rd_en), .rd_ok(frozen),
    .raddr(host_addr), .rdata(host_rdata));

  AST_LO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (mem_we && !mem_wdata[WORD_W-1])); // R2
  AST_HI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (mem_we && mem_wdata[WORD_W-1])); // R2
endmodule

// File: tb/sim_link_ring_recorder.sv
module sim_link_ring_recorder;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int NV = 6;
  // {ctrl[7:0], lanes[63:0]}
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 64'h8877665544332211},
    {8'h01, 64'h0102030405060708},
    {8'h80, 64'hDEADBEEFCAFEF00D},
    {8'h11, 64'hA5A5A5A55A5A5A5A},
    {8'h0E, 64'h0F1E2D3C4B5A6978},
    {8'hF0, 64'hFFEEDDCCBBAA9988}};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, stop_req = 0, restart = 0, host_rd_en = 0;
  logic [63:0] in_lanes = '0;
  logic [7:0] in_ctrl = '0;
  logic [AW-1:0] host_addr = '0;
  logic in_ready, mem_we, frozen, wrapped;
  logic [AW-1:0] mem_addr, wr_ptr;
  logic [35:0] mem_wdata, host_rdata;

  int errs = 0, checks = 0;
  logic [35:0] mdl [DEPTH];
  int eptr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  link_ring_recorder #(.LANES(8), .LANE_W(8), .ADDR_W(AW)) u0 (.*);

  function automatic logic [35:0] exp_word(logic [63:0] l, logic [7:0] c, bit hi);
    return hi ? {1'b1, |c[7:4], 2'b00, l[63:32]} : {1'b0, |c[3:0], 2'b00, l[31:0]};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++; errs++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    #10;
    // R9 reset state
    chk(!frozen && !wrapped && wr_ptr == 0 && !mem_we && host_rdata == 0 && in_ready,
        "R9 reset", {frozen, wrapped, wr_ptr, mem_we, in_ready}, 64'h1);
    @(negedge clk); rst_n = 1;

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1; in_lanes = VEC[i][63:0]; in_ctrl = VEC[i][71:64];
      #1;
      chk(in_ready, "R1 ready", in_ready, 1);
      chk(mem_we && mem_addr == AW'(eptr), "R4 lo addr", mem_addr, eptr);
      chk(mem_wdata == exp_word(in_lanes, in_ctrl, 0), "R2 R3 lo word", mem_wdata,
          exp_word(in_lanes, in_ctrl, 0));
      mdl[eptr] = exp_word(in_lanes, in_ctrl, 0); eptr = (eptr + 1) % DEPTH;
      @(negedge clk);
      in_valid = 1; in_lanes = ~in_lanes; in_ctrl = ~in_ctrl; // must be ignored
      #1;
      chk(!in_ready, "R1 busy", in_ready, 0);
      chk(mem_we && mem_addr == AW'(eptr), "R4 hi addr", mem_addr, eptr);
      chk(mem_wdata == exp_word(VEC[i][63:0], VEC[i][71:64], 1), "R2 R3 hi word",
          mem_wdata, exp_word(VEC[i][63:0], VEC[i][71:64], 1));
      mdl[eptr] = exp_word(VEC[i][63:0], VEC[i][71:64], 1); eptr = (eptr + 1) % DEPTH;
      in_valid = 0;
      @(negedge clk); #1;
      chk(wrapped == (i >= 3), "R5 wrapped", wrapped, i >= 3);
      chk(wr_ptr == AW'(eptr), "R4 ptr", wr_ptr, eptr);
    end

    // R8 restart while recording ignored
    restart = 1; @(negedge clk); restart = 0; #1;
    chk(!frozen && wrapped && wr_ptr == 4, "R8 restart ignored", {wrapped, wr_ptr}, {1'b1, 3'd4});

    // R6 stop during second half
    in_valid = 1; in_lanes = 64'h1234567890ABCDEF; in_ctrl = 8'h20;
    mdl[eptr] = exp_word(in_lanes, in_ctrl, 0); eptr = (eptr + 1) % DEPTH;
    @(negedge clk);
    in_valid = 0; stop_req = 1; #1;
    chk(mem_we && mem_wdata == exp_word(64'h1234567890ABCDEF, 8'h20, 1), "R6 hi finishes",
        mem_wdata, exp_word(64'h1234567890ABCDEF, 8'h20, 1));
    mdl[eptr] = exp_word(64'h1234567890ABCDEF, 8'h20, 1); eptr = (eptr + 1) % DEPTH;
    @(negedge clk); stop_req = 0; in_valid = 1; #1;
    chk(!in_ready && !mem_we, "R1 stop pending", {in_ready, mem_we}, 0);
    @(negedge clk); #1;
    chk(frozen && wr_ptr == 6 && wrapped, "R6 frozen", {frozen, wrapped, wr_ptr}, {2'b11, 3'd6});
    chk(!mem_we && !in_ready, "R6 no writes", {mem_we, in_ready}, 0);
    stop_req = 1; // R8 stop while frozen ignored
    repeat (3) @(negedge clk);
    stop_req = 0; in_valid = 0; #1;
    chk(frozen && wr_ptr == 6, "R6 R8 ptr held", wr_ptr, 6);

    // R7 readout
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); host_rd_en = 1; host_addr = AW'(a);
      @(negedge clk); host_rd_en = 0; #1;
      chk(host_rdata == mdl[a], "R7 readout", host_rdata, mdl[a]);
    end

    // R8 restart while frozen
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0; #1;
    chk(!frozen && !wrapped && wr_ptr == 0 && in_ready, "R8 restart",
        {frozen, wrapped, wr_ptr, in_ready}, 1);

    // R7 read while recording returns zero
    host_rd_en = 1; host_addr = 3'd2;
    @(negedge clk); host_rd_en = 0; #1;
    chk(host_rdata == 0, "R7 idle read", host_rdata, 0);

    finish_run();
  end
endmodule